// File: doc/BRIEF.md
# Filtered Single-Frame Receive Buffer

This block holds one received radio frame between the demodulator's byte stream and a host register interface. A frame arrives as a start strobe, a length byte, then as many payload-and-checksum bytes as the length byte announces. The frame closes with an end strobe that carries the checksum verdict and two status bytes, a link-quality byte and a signal-strength byte. If the frame is complete, passed its checksum and matches the frame-type filter, the block appends the two status bytes after the last checksum byte and emits a one-cycle packet-ready pulse.

The stored frame stays put until the host has read the length byte and the last checksum byte, in either order. Frames that arrive before that release are dropped whole, and a sticky overrun flag records the loss. A control register selects the type filters, enables host writes into the buffer area and offers a self-clearing flush bit. A status register reports the overrun flag and whether a frame is held.

Top module: `rxpkt_buffer`

## Requirements
- R1: After reset the control register (address 0xF0), the status register (address 0xF1) and `pkt_ready` are all 0.
- R2: A stored frame of length L holds the length byte at address 0, the frame bytes at 1..L, the link-quality byte at L+1 and the signal-strength byte at L+2. `pkt_ready` is high for exactly one cycle, in the second cycle after the cycle in which `rx_done` is sampled. Read data appears on `host_rdata` in the cycle after `host_rd`.
- R3: A held frame is released only once the host has read address 0 and address L, in either order. Until then the status bit 1 stays 1.
- R4: A `rx_start` that arrives while a frame is held or is being finished drops that whole frame and sets the status bit 0 (overrun). The overrun bit stays set until the host writes a 1 to status bit 0.
- R5: A frame that fails the checksum, or ends before all L bytes have arrived, raises no `pkt_ready` and leaves the buffer free for the next frame.
- R6: The frame type is the low three bits of the byte at address 1: 000 is beacon, 001 is data and 011 is command. Control bit 3 accepts command frames, bit 2 accepts data frames and bit 1 accepts beacon frames. If several bits are set, any selected type is accepted. If all three are 0, every type is accepted.
- R7: Writing control bit 0 = 1 empties the buffer at once and clears the read tracking. A read issued in the next cycle shows bit 0 as 1. Later reads show 0.
- R8: Host writes to buffer addresses change the buffer only while control bit 4 is 1.
- R9: Control bits 7:5 always read 0. Bits 4:1 read back as they were last written.
- R10: Status bit 1 is 1 exactly while a complete accepted frame is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Frame start strobe from the demodulator |
| rx_valid | input | 1 | Frame byte strobe |
| rx_byte | input | 8 | Frame byte |
| rx_done | input | 1 | Frame end strobe |
| rx_fcs_ok | input | 1 | Checksum verdict, valid with rx_done |
| rx_lqi | input | 8 | Link-quality byte, valid with rx_done |
| rx_rssi | input | 8 | Signal-strength byte, valid with rx_done |
| host_addr | input | 8 | Host address: buffer, control or status |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| pkt_ready | output | 1 | One-cycle frame-stored pulse |

## Verification
The bench sweeps every frame type against every filter setting. A wrong type decode or wrong filter polarity shows up as a stored frame that should have been dropped, or the reverse. It reads back frames of many lengths, including the maximum. An off-by-one in the status-byte placement would put the link-quality byte over the last checksum byte. It releases the buffer in both read orders and probes a single read followed by a new frame: a design that freed the buffer after one read would accept the frame instead of flagging an overrun. It also flushes a frame mid-reception, to catch a design that keeps writing the remaining bytes into the emptied buffer.

// File: rtl/rxpkt_buffer.sv
module rxpkt_buffer #(
  parameter int MAX_LEN = 127,
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [AW-1:0] STAT_ADDR = 8'hF1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_done,
  input  logic          rx_fcs_ok,
  input  logic [7:0]    rx_lqi,
  input  logic [7:0]    rx_rssi,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          pkt_ready
);
  localparam int DEPTH = MAX_LEN + 3;
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);
  localparam logic [7:0] MAX_B = 8'(MAX_LEN);
  localparam logic [1:0] S_EMPTY = 2'd0, S_RECV = 2'd1, S_APP = 2'd2, S_FULL = 2'd3;

  logic [7:0]    mem [DEPTH];
  logic [1:0]    state;
  logic [AW-1:0] cnt;
  logic [LW-1:0] len_q;
  logic [2:0]    ftype;
  logic [7:0]    rssi_q;
  logic [3:0]    cfg;
  logic          len_rd, fcs_rd, ovr, flush_q;

  logic          dm_we;
  logic [AW-1:0] dm_addr;
  logic [7:0]    dm_data;

  wire [AW-1:0] len_a  = AW'(len_q);
  wire ctrl_wr   = host_wr && host_addr == CTRL_ADDR;
  wire stat_wr   = host_wr && host_addr == STAT_ADDR;
  wire flush_req = ctrl_wr && host_wdata[0];
  wire in_buf    = host_addr < DEPTH_A;
  wire busy      = state == S_APP || state == S_FULL;
  wire complete  = cnt == len_a + AW'(1);
  wire type_ok   = (cfg[2:0] == 3'b000) ||
                   (cfg[2] && ftype == 3'b011) ||
                   (cfg[1] && ftype == 3'b001) ||
                   (cfg[0] && ftype == 3'b000);
  wire accept    = rx_fcs_ok && complete && type_ok;
  wire rd_len    = host_rd && state == S_FULL && host_addr == '0;
  wire rd_fcs    = host_rd && state == S_FULL && host_addr == len_a;
  wire release_now = (len_rd || rd_len) && (fcs_rd || rd_fcs);

  always_comb begin
    dm_we   = 1'b0;
    dm_addr = '0;
    dm_data = 8'h00;
    if (state == S_RECV && !rx_start) begin
      if (rx_valid && (cnt == '0 || cnt <= len_a)) begin
        dm_we   = 1'b1;
        dm_addr = cnt;
        dm_data = rx_byte;
      end else if (!rx_valid && rx_done && accept) begin
        dm_we   = 1'b1;
        dm_addr = len_a + AW'(1);
        dm_data = rx_lqi;
      end
    end else if (state == S_APP) begin
      dm_we   = 1'b1;
      dm_addr = len_a + AW'(2);
      dm_data = rssi_q;
    end
  end

  always_ff @(posedge clk) begin
    if (dm_we) mem[dm_addr] <= dm_data;
    if (host_wr && cfg[3] && in_buf && !(dm_we && dm_addr == host_addr))
      mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_EMPTY;
      cnt       <= '0;
      len_q     <= '0;
      ftype     <= 3'b111;
      rssi_q    <= 8'h00;
      cfg       <= 4'h0;
      len_rd    <= 1'b0;
      fcs_rd    <= 1'b0;
      ovr       <= 1'b0;
      flush_q   <= 1'b0;
      pkt_ready <= 1'b0;
    end else begin
      pkt_ready <= 1'b0;
      flush_q   <= flush_req;
      if (ctrl_wr) cfg <= host_wdata[4:1];
      if (stat_wr && host_wdata[0]) ovr <= 1'b0;
      if (rx_start && busy) ovr <= 1'b1;
      case (state)
        S_EMPTY: if (rx_start) begin
          state <= S_RECV;
          cnt   <= '0;
          ftype <= 3'b111;
        end
        S_RECV: begin
          if (rx_start) begin
            cnt   <= '0;
            ftype <= 3'b111;
          end else if (rx_valid) begin
            if (dm_we) cnt <= cnt + AW'(1);
            if (cnt == '0) len_q <= (rx_byte > MAX_B) ? LW'(MAX_LEN) : rx_byte[LW-1:0];
            if (cnt == AW'(1) && dm_we) ftype <= rx_byte[2:0];
          end else if (rx_done) begin
            if (accept) begin
              state  <= S_APP;
              rssi_q <= rx_rssi;
            end else begin
              state <= S_EMPTY;
            end
          end
        end
        S_APP: begin
          state     <= S_FULL;
          pkt_ready <= 1'b1;
          len_rd    <= 1'b0;
          fcs_rd    <= 1'b0;
        end
        default: begin
          if (release_now) begin
            state  <= S_EMPTY;
            len_rd <= 1'b0;
            fcs_rd <= 1'b0;
          end else begin
            len_rd <= len_rd || rd_len;
            fcs_rd <= fcs_rd || rd_fcs;
          end
        end
      endcase
      if (flush_req) begin
        state     <= S_EMPTY;
        len_rd    <= 1'b0;
        fcs_rd    <= 1'b0;
        pkt_ready <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= 8'h00;
    else if (host_rd) begin
      if (host_addr == CTRL_ADDR)      host_rdata <= {3'b000, cfg, flush_q};
      else if (host_addr == STAT_ADDR) host_rdata <= {6'b0, state == S_FULL, ovr};
      else if (in_buf)                 host_rdata <= mem[host_addr];
      else                             host_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/rxpkt_buffer_chk.sv
module rxpkt_buffer_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [AW-1:0] STAT_ADDR = 8'hF1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic          pkt_ready,
  input logic          flush_q,
  input logic          ovr,
  input logic          rx_start,
  input logic          host_rd,
  input logic          host_wr,
  input logic [AW-1:0] host_addr,
  input logic [7:0]    host_wdata
);
  wire flush_w = host_wr && host_addr == CTRL_ADDR && host_wdata[0];
  wire clr_w   = host_wr && host_addr == STAT_ADDR && host_wdata[0];

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> !pkt_ready);
  assert_ready_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> state == 2'd3);
  assert_hold_until_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !host_rd && !flush_w) |=> state == 2'd3);
  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && (state == 2'd2 || state == 2'd3)) |=> ovr);
  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_w) |=> ovr);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (state == 2'd0 && !pkt_ready));
  assert_flush_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);
endmodule

bind rxpkt_buffer rxpkt_buffer_chk #(.AW(AW), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .pkt_ready(pkt_ready), .flush_q(flush_q),
  .ovr(ovr), .rx_start(rx_start), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata)
);

// File: tb/test_rxpkt_buffer.sv
module test_rxpkt_buffer;
  localparam int MAX_LEN = 127;
  localparam logic [7:0] CTRL = 8'hF0, STAT = 8'hF1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 0, rx_valid = 0, rx_done = 0, rx_fcs_ok = 0;
  logic [7:0] rx_byte = 0, rx_lqi = 0, rx_rssi = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] host_rdata;
  logic pkt_ready;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rxpkt_buffer #(.MAX_LEN(MAX_LEN)) i_rxpkt_buffer (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1; tick; host_rd = 0; d = host_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    host_addr = a; host_wdata = v; host_wr = 1; tick; host_wr = 0;
  endtask

  function automatic logic [7:0] fbyte(input int l, input int i, input logic [2:0] t);
    return (i == 1) ? {5'b10100, t} : 8'((i * 13 + l) & 255);
  endfunction

  task automatic start_frame; rx_start = 1; tick; rx_start = 0; endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; tick; rx_valid = 0;
  endtask

  task automatic push_body(input int l, input logic [2:0] t, input int n);
    push(8'(l));
    for (int i = 1; i <= n; i++) push(fbyte(l, i, t));
  endtask

  task automatic finish_frame(input int l, input logic ok, input logic exp, input string tag);
    logic r1, r2, r3;
    rx_done = 1; rx_fcs_ok = ok; rx_lqi = 8'(8'h40 + l); rx_rssi = 8'(8'hC0 ^ l);
    tick; rx_done = 0; r1 = pkt_ready;
    tick; r2 = pkt_ready;
    tick; r3 = pkt_ready;
    chk(tag, {29'd0, r1, r2, r3}, {29'd0, 1'b0, exp, 1'b0});
  endtask

  task automatic send(input int l, input logic [2:0] t, input logic ok, input logic exp, input string tag);
    start_frame; push_body(l, t, l); finish_frame(l, ok, exp, tag);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog got timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick;
    rst_n = 1; tick;

    rd(CTRL, d); chk("R1 ctrl reset", d, 8'h00);
    rd(STAT, d); chk("R1 status reset", d, 8'h00);
    chk("R1 pkt_ready reset", pkt_ready, 0);

    foreach (d[k]) ;
    for (int k = 0; k < 7; k++) begin
      int l;
      l = (k == 6) ? MAX_LEN : ((k * k) + 1);
      send(l, 3'b001, 1'b1, 1'b1, "R2 ready pulse");
      for (int i = 1; i < l; i++) begin
        rd(8'(i), d); chk("R2 frame byte", d, fbyte(l, i, 3'b001));
      end
      rd(8'(l + 1), d); chk("R2 lqi byte", d, 8'(8'h40 + l));
      rd(8'(l + 2), d); chk("R2 rssi byte", d, 8'(8'hC0 ^ l));
      rd(8'h00, d); chk("R2 length byte", d, 8'(l));
      rd(STAT, d); chk("R10 held after length read", d, 8'h02);
      rd(8'(l), d); chk("R2 last fcs byte", d, fbyte(l, l, 3'b001));
      rd(STAT, d); chk("R3 released", d, 8'h00);
    end

    send(6, 3'b001, 1'b1, 1'b1, "R3 setup");
    rd(8'h00, d);
    send(6, 3'b011, 1'b1, 1'b0, "R4 dropped frame no ready");
    rd(STAT, d); chk("R4 overrun with frame held", d, 8'h03);
    rd(8'h02, d); chk("R4 held frame intact", d, fbyte(6, 2, 3'b001));
    rd(8'h01, d); chk("R4 held frame type intact", d, fbyte(6, 1, 3'b001));
    rd(8'h06, d);
    rd(STAT, d); chk("R4 overrun sticky after release", d, 8'h01);
    wr(STAT, 8'h01);
    rd(STAT, d); chk("R4 overrun cleared", d, 8'h00);
    send(5, 3'b000, 1'b1, 1'b1, "R3 accept after release");
    rd(8'h05, d);
    rd(STAT, d); chk("R3 fcs read alone keeps frame", d, 8'h02);
    rd(8'h00, d);
    rd(STAT, d); chk("R3 released fcs-then-length", d, 8'h00);

    send(4, 3'b001, 1'b0, 1'b0, "R5 bad fcs no ready");
    rd(STAT, d); chk("R5 bad fcs buffer free", d, 8'h00);
    start_frame; push_body(7, 3'b001, 5); finish_frame(7, 1'b1, 1'b0, "R5 short frame no ready");
    rd(STAT, d); chk("R5 short frame buffer free", d, 8'h00);
    send(3, 3'b001, 1'b1, 1'b1, "R5 next frame accepted");

    wr(8'h03, 8'h5A);
    rd(8'h03, d); chk("R8 write ignored when disabled", d, fbyte(3, 3, 3'b001));
    wr(CTRL, 8'h10);
    wr(8'h03, 8'h5A);
    rd(8'h03, d); chk("R8 write applied when enabled", d, 8'h5A);

    wr(CTRL, 8'h11);
    rd(CTRL, d); chk("R7 flush bit visible next cycle", d, 8'h11);
    rd(CTRL, d); chk("R7 flush bit self-cleared", d, 8'h10);
    rd(STAT, d); chk("R7 flush empties", d, 8'h00);
    start_frame; push_body(6, 3'b001, 2);
    wr(CTRL, 8'h01);
    for (int i = 3; i <= 6; i++) push(fbyte(6, i, 3'b001));
    finish_frame(6, 1'b1, 1'b0, "R7 flush mid-frame no ready");
    rd(STAT, d); chk("R7 flush mid-frame stays empty", d, 8'h00);

    wr(CTRL, 8'hFE);
    rd(CTRL, d); chk("R9 upper bits read zero", d, 8'h1E);
    wr(CTRL, 8'hE0);
    rd(CTRL, d); chk("R9 reserved bits ignored", d, 8'h00);

    for (int f = 0; f < 8; f++) begin
      for (int t = 0; t < 8; t++) begin
        logic acc;
        acc = (f == 0) || (f[2] && t == 3) || (f[1] && t == 1) || (f[0] && t == 0);
        wr(CTRL, 8'(f << 1));
        send(4, 3'(t), 1'b1, acc, "R6 filter ready");
        rd(STAT, d); chk("R6 R10 filter held", d, {6'b0, acc, 1'b0});
        if (acc) wr(CTRL, 8'((f << 1) | 1));
      end
    end

    summary;
    $finish;
  end
endmodule